// File: doc/BRIEF.md
# SPI Peripheral Interrupt and Soft-Reset Controller

This block sits beside a SPI core on a 32-bit register bus and turns the core's event lines into a single interrupt request. Each event line is watched for a low-to-high transition. A transition latches a pending bit in a status register. Pending bits are masked by a per-source enable register. The combined request is then qualified by one global enable bit before it drives a registered interrupt output.

The same register window holds a keyed software reset. Writing the correct key produces a fixed-length reset pulse for the SPI core. Writing any other value raises a sticky error flag and issues no reset. Neither the software reset nor the error flag changes the enable settings held in this block.

Software services an interrupt as follows. It reads the status register and writes the same value back to clear the bits it has seen. It then continues with the core's own registers.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `core_rst_o` and `key_err_o` are 0, and every register reads back 0.
- R2: The global enable is bit 31 of the register at byte offset 0x1C, and only that bit is stored. While it is 0, `irq_o` stays 0 whatever is pending.
- R3: The status register is at offset 0x20. Writing a 1 to any of its bits clears that pending bit, and writing a 0 leaves the bit unchanged.
- R4: A status bit is set on a rising edge of its event input. A level that stays high does not set the bit again after it is cleared. If a rising edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R5: Writing 0x0000000A to offset 0x40 drives `core_rst_o` high for exactly 16 consecutive cycles, starting in the cycle after the write.
- R6: Writing any value other than 0x0000000A to offset 0x40 raises no reset pulse and sets `key_err_o`. The flag stays set until a correct key write clears it, and it reads back as bit 0 of offset 0x40.
- R7: The per-source enable is bits 6:0 at offset 0x28. A source with its enable bit at 0 cannot raise `irq_o`, and writing 0 masks every source.
- R8: `irq_o` is registered. It rises one cycle after the cycle in which the status register, the enable register and the global enable together first hold a request.
- R9: A software reset changes neither the global enable, the enable register nor the pending status bits.
- R10: The source bit assignment is as follows: bit 0 mode fault, bit 1 slave-select fault, bit 2 TX FIFO empty, bit 3 TX underrun, bit 4 RX full, bit 5 RX overrun, bit 6 TX half empty. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 7 | Event lines from the SPI core |
| irq_o | output | 1 | Registered interrupt request |
| core_rst_o | output | 1 | Reset pulse to the SPI core, active high |
| key_err_o | output | 1 | Sticky error flag for a wrong reset key |

## Verification
A wrong pending bit shows up in two places. It appears on the status readback at the very next read. It also reaches `irq_o` exactly one clock later, so a latch that fails to set, or that lets a clear beat a set, is visible within two cycles. A reset counter that is off by one shows up as a pulse of 15 or 17 cycles at `core_rst_o`. A decode fault on the key shows up as a pulse where none should be, or as a missing `key_err_o` one cycle after the write. Enable registers that were lost to a software reset show up at the next readback and at `irq_o` going quiet.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;
  localparam int unsigned NSRC      = 7;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned RST_LEN   = 16;

  localparam logic [ADDR_W-1:0] OFS_GIE  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_SRST = 8'h40;
  localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;
  localparam int unsigned       GIE_BIT  = 31;

  // next pending state: clears first, new edges on top (set wins)
  function automatic logic [NSRC-1:0] pend_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] rise,
                                                input logic [NSRC-1:0] clr);
    return (cur & ~clr) | rise;
  endfunction

  function automatic logic irq_req(input logic [NSRC-1:0] st,
                                   input logic [NSRC-1:0] en,
                                   input logic            gie);
    return gie & (|(st & en));
  endfunction
endpackage

// File: rtl/pirq_edge_latch.sv
`timescale 1ns/1ps
module pirq_edge_latch #(
  parameter int unsigned N = pirq_pkg::NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] evt_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    assign rise_o[g] = evt_i[g] & ~evt_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q    <= '0;
      status_o <= '0;
    end else begin
      evt_q    <= evt_i;
      status_o <= pirq_pkg::pend_next(status_o, rise_o, clr_i);
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((status_o & $past(rise_o)) == $past(rise_o))); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~rise_o)) |=> ((status_o & $past(clr_i & ~rise_o)) == '0)); // R3
endmodule

// File: rtl/pirq_gate.sv
`timescale 1ns/1ps
module pirq_gate #(
  parameter int unsigned N = pirq_pkg::NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic         irq_o
);
  logic req_now;
  assign req_now = pirq_pkg::irq_req(status_i, en_i, gie_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= req_now;
  end

  AST_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o); // R2
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o); // R7
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_i && |(status_i & en_i)) |=> irq_o); // R8
endmodule

// File: rtl/pirq_soft_reset.sv
`timescale 1ns/1ps
module pirq_soft_reset #(
  parameter int unsigned CYC = pirq_pkg::RST_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr_i,
  input  logic bad_wr_i,
  output logic core_rst_o,
  output logic key_err_o
);
  localparam int unsigned CNT_W = $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      key_err_o <= 1'b0;
    end else begin
      if (key_wr_i)          cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      if (key_wr_i)          key_err_o <= 1'b0;
      else if (bad_wr_i)     key_err_o <= 1'b1;
    end
  end

  assign core_rst_o = (cnt_q != '0);

  AST_KEY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_i |=> core_rst_o); // R5
  AST_BAD_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr_i && !core_rst_o) |=> !core_rst_o); // R6
  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr_i |=> key_err_o); // R6
endmodule

// File: rtl/pirq_ctrl.sv
`timescale 1ns/1ps
module pirq_ctrl #(
  parameter int unsigned N_SRC   = pirq_pkg::NSRC,
  parameter int unsigned RST_CYC = pirq_pkg::RST_LEN
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [pirq_pkg::ADDR_W-1:0]  bus_addr,
  input  logic [pirq_pkg::DATA_W-1:0]  bus_wdata,
  output logic [pirq_pkg::DATA_W-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]             evt_i,
  output logic                         irq_o,
  output logic                         core_rst_o,
  output logic                         key_err_o
);
  import pirq_pkg::*;
  localparam int unsigned PAD = DATA_W - N_SRC;

  logic             gie_q;
  logic [N_SRC-1:0] ien_q;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] clr_mask;
  logic             wr_gie, wr_stat, wr_ien, wr_srst;
  logic             key_wr, bad_wr;

  // register decode
  assign wr_gie  = bus_wr && (bus_addr == OFS_GIE);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign wr_srst = bus_wr && (bus_addr == OFS_SRST);
  assign key_wr  = wr_srst && (bus_wdata == SRST_KEY);
  assign bad_wr  = wr_srst && (bus_wdata != SRST_KEY);
  assign clr_mask = wr_stat ? bus_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (wr_gie) gie_q <= bus_wdata[GIE_BIT];
      if (wr_ien) ien_q <= bus_wdata[N_SRC-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_GIE:  bus_rdata[GIE_BIT] = gie_q;
      OFS_STAT: bus_rdata = {{PAD{1'b0}}, status};
      OFS_IEN:  bus_rdata = {{PAD{1'b0}}, ien_q};
      OFS_SRST: bus_rdata[0] = key_err_o;
      default:  bus_rdata = '0;
    endcase
  end

  pirq_edge_latch #(.N(N_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_mask),
    .status_o(status), .rise_o(rise)
  );

  pirq_gate #(.N(N_SRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .status_i(status), .en_i(ien_q),
    .gie_i(gie_q), .irq_o(irq_o)
  );

  pirq_soft_reset #(.CYC(RST_CYC)) u_srst (
    .clk(clk), .rst_n(rst_n), .key_wr_i(key_wr), .bad_wr_i(bad_wr),
    .core_rst_o(core_rst_o), .key_err_o(key_err_o)
  );

  AST_KEEP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (gie_q == $past(gie_q)) && (ien_q == $past(ien_q))); // R9
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_gie && !wr_ien) |=> $stable(gie_q) && $stable(ien_q)); // R10
endmodule

// File: tb/tb_pirq_ctrl.sv
`timescale 1ns/1ps
module tb_pirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_i = '0;
  logic        irq_o, core_rst_o, key_err_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [7:0] A_GIE = 8'h1C, A_ST = 8'h20, A_IE = 8'h28, A_RST = 8'h40;

  always #2.5 clk = ~clk;

  pirq_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o),
    .core_rst_o(core_rst_o), .key_err_o(key_err_o));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1", "irq", {31'b0, irq_o}, 0);
    check("R1", "core_rst", {31'b0, core_rst_o}, 0);
    check("R1", "key_err", {31'b0, key_err_o}, 0);
    rd(A_GIE, v); check("R1", "gie reg", v, 0);
    rd(A_ST, v);  check("R1", "status reg", v, 0);
    rd(A_IE, v);  check("R1", "enable reg", v, 0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(A_IE, 32'h7F); wr(A_GIE, 32'h8000_0000);
    evt_i = 7'h04;             // TX empty, bit 2
    @(negedge clk);
    rd(A_ST, v); check("R4", "latched on rise", v, 32'h04);
    check("R8", "irq not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R8", "irq one cycle later", {31'b0, irq_o}, 1);
    wr(A_ST, 32'h04);          // clear while level still high
    cyc(2);
    rd(A_ST, v); check("R4", "held level no retrigger", v, 0);
    check("R3", "irq drops", {31'b0, irq_o}, 0);
    evt_i = '0; cyc(1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    evt_i = 7'h21; @(negedge clk); evt_i = '0; @(negedge clk);
    rd(A_ST, v); check("R10", "two sources", v, 32'h21);
    wr(A_ST, 32'h01);
    rd(A_ST, v); check("R3", "clear one bit", v, 32'h20);
    wr(A_ST, 32'h00);
    rd(A_ST, v); check("R3", "zero write keeps", v, 32'h20);
    wr(A_ST, 32'h20);
    rd(A_ST, v); check("R3", "clear other", v, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    evt_i = 7'h02; @(negedge clk); evt_i = '0; @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_ST; bus_wdata = 32'h02; evt_i = 7'h02;
    @(negedge clk); bus_wr = 1'b0;
    rd(A_ST, v); check("R4", "set beats clear", v, 32'h02);
    wr(A_ST, 32'h02);
    rd(A_ST, v); check("R4", "clear after", v, 0);
    evt_i = '0; cyc(1);
  endtask

  task automatic t_gie;
    logic [31:0] v;
    evt_i = 7'h08; @(negedge clk); evt_i = '0;
    wr(A_GIE, 32'h0); cyc(2);
    check("R2", "gie off blocks", {31'b0, irq_o}, 0);
    wr(A_GIE, 32'h7FFF_FFFF); cyc(2);
    check("R2", "other bits no effect", {31'b0, irq_o}, 0);
    rd(A_GIE, v); check("R2", "only bit31 stored", v, 0);
    wr(A_GIE, 32'h8000_0000); @(negedge clk);
    check("R2", "gie on", {31'b0, irq_o}, 1);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(A_IE, 32'h0); cyc(1);
    check("R7", "zero masks all", {31'b0, irq_o}, 0);
    wr(A_IE, 32'h08); cyc(1);
    check("R7", "bit3 enabled", {31'b0, irq_o}, 1);
    wr(A_IE, 32'h01); cyc(1);
    check("R7", "other source only", {31'b0, irq_o}, 0);
    wr(8'h24, 32'h7F);
    rd(A_IE, v); check("R10", "stray offset ignored", v, 32'h01);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    int n = 0;
    wr(A_RST, 32'h0000_000A);
    while (core_rst_o && n < 100) begin n++; @(negedge clk); end
    check("R5", "pulse length", n, 16);
    check("R5", "no error", {31'b0, key_err_o}, 0);
    rd(A_GIE, v); check("R9", "gie kept", v, 32'h8000_0000);
    rd(A_IE, v);  check("R9", "enable kept", v, 32'h01);
    rd(A_ST, v);  check("R9", "status kept", v, 32'h08);
  endtask

  task automatic t_bad;
    logic [31:0] v;
    int hits = 0;
    wr(A_RST, 32'h0000_000B);
    check("R6", "error flag", {31'b0, key_err_o}, 1);
    for (int i = 0; i < 4; i++) begin
      if (core_rst_o) hits++;
      @(negedge clk);
    end
    check("R6", "no pulse", hits, 0);
    rd(A_RST, v); check("R6", "flag readback", v, 32'h1);
    wr(A_RST, 32'h0000_000A);
    check("R6", "flag cleared by key", {31'b0, key_err_o}, 0);
    cyc(20);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_edge();
    t_w1c();
    t_set_wins();
    t_gie();
    t_mask();
    t_soft();
    t_bad();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule